// File: doc/BRIEF.md
# Timebase Interval Timer

This block is a free-running timebase that other peripherals use as a slow reference and as a periodic event source. A wide down-counter starts at all ones and drops by one on every second cycle of the main clock. A power-of-two interval is chosen through a control register. Each time that interval has passed since the counter was last reloaded, the block sets an interval flag. The flag can raise an interrupt request.

The counter goes back to all ones in several cases: software asks for it, the main clock stops, or the clock controller leaves main (or main-PLL) operation for stop, subclock or sub-PLL operation. A low-voltage-detect reset and the power-on reset also reload it. A dependent watchdog may be configured to count from this timebase. In that case, every reload is passed on to it as a one-cycle clear pulse, so that its count stays consistent with the timebase.

The 8-bit control register holds four fields. Bit 7 is the flag, bit 6 is the interrupt enable, and the interval select is split across bits 5 and 1. Bit 0 is a write-only reload strobe.

Top module: `tbt_interval_timer`

## Requirements
- R1: After reset the timebase output is all ones, the control register reads 0x00, and both the interrupt request and the watchdog clear are low.
- R2: While the main clock runs and no reload happens, the timebase drops by exactly one on every second clock cycle. The first cycle after a reload is a non-counting phase.
- R3: Writing the control register with bit 0 set reloads the timebase to all ones on that write's clock edge. Bit 0 always reads back as 0.
- R4: The interval select is {bit5, bit1}. Values 0, 1, 2 and 3 pick counter taps TAP0..TAP3 (defaults 9, 11, 13, 20). The flag (bit 7) sets when the picked tap goes from 0 to 1 during a count step. That happens after 2^(tap+1) steps, and every 2^(tap+1) steps after that, counted from the most recent reload.
- R5: A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves it unchanged. If a flag-setting step and a flag-clearing write land on the same edge, the flag ends up set.
- R6: The interrupt request is high exactly when both the flag and the enable (bit 6) are 1.
- R7: While the main-clock-running input is low, the timebase is held at all ones, no count steps occur and the flag is never set.
- R8: The mode input uses the encoding main=0, main-PLL=1, subclock=2, sub-PLL=3, stop=4. A change from 0 or 1 to 2, 3 or 4 reloads the timebase. No other mode change reloads it.
- R9: A high level on the low-voltage-reset input reloads the timebase on that edge.
- R10: The watchdog clear output is high for the cycle after any reload (R3, R7, R8, R9) when the watchdog-source select is high. Otherwise it stays low.
- R11: A reload on the same edge as a tap transition wins: the flag is not set. The next interval is measured from that reload.
- R12: Bits 4 to 2 read as 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| main_run_i | input | 1 | High while the main oscillator runs |
| mode_i | input | 3 | Current clock mode (encoding in R8) |
| lvd_rst_i | input | 1 | Low-voltage-detect reset event |
| wdt_src_sel_i | input | 1 | Watchdog counts from this timebase |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| irq_o | output | 1 | Interval interrupt request |
| wdt_clr_o | output | 1 | Clear pulse to the dependent watchdog |
| timebase_o | output | CNT_W (22) | Current counter value |

## Verification
The hardest case to reach is a reload that lands on exactly the edge where the selected tap borrows. A close second is a flag-clearing write that coincides with that borrow. Both depend on the hidden divide-by-two phase. The stimulus starts from a known reload and counts a fixed number of whole cycles before issuing the second write. This places the write on the 2·2^(tap+1)-th edge. The longest interval takes millions of cycles at full width, so the bench shrinks the counter and tap parameters. This brings every select value into reach while the select-to-tap mapping is kept.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int CTRL_W     = 8;
    localparam int FLAG_BIT   = 7;
    localparam int IE_BIT     = 6;
    localparam int SEL_HI_BIT = 5;
    localparam int SEL_LO_BIT = 1;
    localparam int CLR_BIT    = 0;
    localparam int NUM_SEL    = 4;

    typedef enum logic [2:0] {
        MODE_MAIN     = 3'd0,
        MODE_MAIN_PLL = 3'd1,
        MODE_SUB      = 3'd2,
        MODE_SUB_PLL  = 3'd3,
        MODE_STOP     = 3'd4
    } clk_mode_e;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [1:0] sel;
    } ctrl_state_t;

    typedef struct packed {
        logic [2:0] prev_mode;
        logic       wdt_clr;
    } clrgen_state_t;

    function automatic logic mode_on_main(input logic [2:0] m);
        return (m == MODE_MAIN) || (m == MODE_MAIN_PLL);
    endfunction

    function automatic logic mode_off_main(input logic [2:0] m);
        return (m == MODE_SUB) || (m == MODE_SUB_PLL) || (m == MODE_STOP);
    endfunction

endpackage

// File: rtl/tbt_clear_gen.sv
module tbt_clear_gen
    import tbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       main_run_i,
    input  logic       lvd_rst_i,
    input  logic       sw_clr_i,
    input  logic       wdt_src_sel_i,
    output logic       clr_o,
    output logic       wdt_clr_o
);

    clrgen_state_t st_d, st_q;
    logic          leave_main;

    always_comb begin
        leave_main = mode_on_main(st_q.prev_mode) && mode_off_main(mode_i);
        clr_o      = sw_clr_i || lvd_rst_i || !main_run_i || leave_main;
        st_d           = st_q;
        st_d.prev_mode = mode_i;
        st_d.wdt_clr   = clr_o && wdt_src_sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev_mode <= MODE_MAIN;
            st_q.wdt_clr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wdt_clr_o = st_q.wdt_clr;

    // R10: a watchdog clear only follows a cycle where the source select was high
    assert_wdt_clr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |-> $past(wdt_src_sel_i));

    // R8: leaving main operation always produces a reload request
    assert_mode_exit_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == MODE_MAIN && mode_i == MODE_STOP) |-> clr_o);

endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
    parameter int CNT_W = 22,
    parameter int TAP0  = 9,
    parameter int TAP1  = 11,
    parameter int TAP2  = 13,
    parameter int TAP3  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tap_rise_o
);

    localparam logic [CNT_W-1:0] RELOAD = '1;
    localparam int TAP_IDX [4] = '{TAP0, TAP1, TAP2, TAP3};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] cnt_dec;
    logic [3:0]       rise_v;

    assign cnt_dec = st_q.cnt - CNT_W'(1);

    for (genvar g = 0; g < 4; g++) begin : g_tap
        assign rise_v[g] = !clr_i && st_q.phase &&
                           !st_q.cnt[TAP_IDX[g]] && cnt_dec[TAP_IDX[g]];
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt   = RELOAD;
            st_d.phase = 1'b0;
        end else begin
            st_d.phase = !st_q.phase;
            if (st_q.phase) begin
                st_d.cnt = cnt_dec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= RELOAD;
            st_q.phase <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o      = st_q.cnt;
    assign tap_rise_o = rise_v[sel_i];

    // R3: any reload request leaves the counter at all ones
    assert_reload_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == RELOAD));

    // R2: the non-counting phase holds the value
    assert_half_rate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !st_q.phase) |=> $stable(cnt_o));

    // R2: the counting phase takes exactly one step
    assert_half_rate_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && st_q.phase) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

endmodule

// File: rtl/tbt_ctrl_reg.sv
module tbt_ctrl_reg
    import tbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              tap_rise_i,
    output logic [CTRL_W-1:0] rd_data_o,
    output logic [1:0]        sel_o,
    output logic              ie_o,
    output logic              flag_o,
    output logic              sw_clr_o
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ie  = wr_data_i[IE_BIT];
            st_d.sel = {wr_data_i[SEL_HI_BIT], wr_data_i[SEL_LO_BIT]};
            if (!wr_data_i[FLAG_BIT]) begin
                st_d.flag = 1'b0;
            end
        end
        if (tap_rise_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o             = '0;
        rd_data_o[FLAG_BIT]   = st_q.flag;
        rd_data_o[IE_BIT]     = st_q.ie;
        rd_data_o[SEL_HI_BIT] = st_q.sel[1];
        rd_data_o[SEL_LO_BIT] = st_q.sel[0];
    end

    assign sel_o    = st_q.sel;
    assign ie_o     = st_q.ie;
    assign flag_o   = st_q.flag;
    assign sw_clr_o = wr_en_i && wr_data_i[CLR_BIT];

    // R4: a tap transition sets the flag
    assert_tap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_rise_i |=> flag_o);

    // R5: writing 0 to the flag clears it when no tap transition competes
    assert_flag_write_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[FLAG_BIT] && !tap_rise_i) |=> !flag_o);

    // R5: writing 1 to the flag never sets it
    assert_flag_write_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[FLAG_BIT] && !tap_rise_i && !flag_o) |=> !flag_o);

endmodule

// File: rtl/tbt_interval_timer.sv
module tbt_interval_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W = 22,
    parameter int TAP0  = 9,
    parameter int TAP1  = 11,
    parameter int TAP2  = 13,
    parameter int TAP3  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_run_i,
    input  logic [2:0]       mode_i,
    input  logic             lvd_rst_i,
    input  logic             wdt_src_sel_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    output logic [7:0]       rd_data_o,
    output logic             irq_o,
    output logic             wdt_clr_o,
    output logic [CNT_W-1:0] timebase_o
);

    logic       clr_w;
    logic       sw_clr_w;
    logic       tap_rise_w;
    logic [1:0] sel_w;
    logic       ie_w;
    logic       flag_w;

    tbt_clear_gen u_clear_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .main_run_i    (main_run_i),
        .lvd_rst_i     (lvd_rst_i),
        .sw_clr_i      (sw_clr_w),
        .wdt_src_sel_i (wdt_src_sel_i),
        .clr_o         (clr_w),
        .wdt_clr_o     (wdt_clr_o)
    );

    tbt_counter #(
        .CNT_W (CNT_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_w),
        .sel_i      (sel_w),
        .cnt_o      (timebase_o),
        .tap_rise_o (tap_rise_w)
    );

    tbt_ctrl_reg u_ctrl_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .tap_rise_i (tap_rise_w),
        .rd_data_o  (rd_data_o),
        .sel_o      (sel_w),
        .ie_o       (ie_w),
        .flag_o     (flag_w),
        .sw_clr_o   (sw_clr_w)
    );

    assign irq_o = flag_w && ie_w;

    // R10: every reload reaches the watchdog when it counts from this timebase
    assert_wdt_follows_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && wdt_src_sel_i) |=> wdt_clr_o);

    // R11: a reload never leaves a freshly set flag behind
    assert_clear_beats_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !flag_w) |=> !flag_w);

    // R7: a halted main clock keeps the timebase at all ones
    assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !main_run_i |=> (timebase_o == {CNT_W{1'b1}}));

endmodule

// File: tb/tbt_interval_timer_bench.sv
module tbt_interval_timer_bench;

    localparam int W  = 16;
    localparam int T0 = 3;
    localparam int T1 = 5;
    localparam int T2 = 7;
    localparam int T3 = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         main_run = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         lvd = 1'b0;
    logic         wsel = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_data = 8'h00;
    logic [7:0]   rd_data;
    logic         irq;
    logic         wdt_clr;
    logic [W-1:0] tbase;

    always #10 clk = ~clk;

    tbt_interval_timer #(
        .CNT_W (W), .TAP0 (T0), .TAP1 (T1), .TAP2 (T2), .TAP3 (T3)
    ) u_tbt_interval_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .main_run_i    (main_run),
        .mode_i        (mode),
        .lvd_rst_i     (lvd),
        .wdt_src_sel_i (wsel),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .irq_o         (irq),
        .wdt_clr_o     (wdt_clr),
        .timebase_o    (tbase)
    );

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // behavioural reference: steps elapsed since the last reload
    int       m_steps;
    bit       m_ph;
    bit       m_flag;
    bit       m_ie;
    bit       m_wclr;
    bit [1:0] m_sel;
    int       m_prev;

    function automatic int period(input bit [1:0] s);
        case (s)
            2'd0:    return 1 << (T0 + 1);
            2'd1:    return 1 << (T1 + 1);
            2'd2:    return 1 << (T2 + 1);
            default: return 1 << (T3 + 1);
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_steps = 0; m_ph = 0; m_flag = 0; m_ie = 0; m_wclr = 0; m_sel = 0; m_prev = 0;
        end else begin
            bit leave;
            bit clr;
            bit nflag;
            leave = (m_prev == 0 || m_prev == 1) && (mode == 2 || mode == 3 || mode == 4);
            clr   = (wr_en && wr_data[0]) || lvd || !main_run || leave;
            nflag = m_flag;
            if (wr_en && !wr_data[7]) nflag = 0;
            if (!clr && m_ph && ((m_steps + 1) % period(m_sel)) == 0) nflag = 1;
            m_flag = nflag;
            if (wr_en) begin
                m_ie  = wr_data[6];
                m_sel = {wr_data[5], wr_data[1]};
            end
            m_wclr = clr && wsel;
            if (clr) begin
                m_steps = 0;
                m_ph    = 0;
            end else begin
                if (m_ph) m_steps = (m_steps + 1) % (1 << W);
                m_ph = !m_ph;
            end
            m_prev = int'(mode);
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "timebase", 32'(tbase), 32'((1 << W) - 1 - m_steps));
            chk(cur_req, "rd_data", 32'(rd_data),
                32'({m_flag, m_ie, m_sel[1], 3'b000, m_sel[0], 1'b0}));
            chk(cur_req, "irq", 32'(irq), 32'(m_flag && m_ie));
            chk(cur_req, "wdt_clr", 32'(wdt_clr), 32'(m_wclr));
        end
    end

    // called at a negedge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        run(1);
        cur_req = "R1";
        chk("R1", "reset timebase", 32'(tbase), 32'hFFFF);
        chk("R1", "reset rd_data", 32'(rd_data), 32'h00);
        chk("R1", "reset irq", 32'(irq), 32'h0);
        chk("R1", "reset wdt_clr", 32'(wdt_clr), 32'h0);

        cur_req = "R2";
        main_run = 1'b1;
        run(40);
        chk("R2", "after 40 cycles", 32'(tbase), 32'hFFEB);

        cur_req = "R3";
        wr(8'h01);
        chk("R3", "sw reload", 32'(tbase), 32'hFFFF);
        chk("R3", "clear bit reads 0", 32'(rd_data), 32'h00);

        cur_req = "R4";
        wr(8'h41);
        run(31);
        chk("R4", "flag before interval", 32'(rd_data[7]), 32'h0);
        run(1);
        chk("R4", "flag at sel0 interval", 32'(rd_data[7]), 32'h1);
        cur_req = "R6";
        chk("R6", "irq with enable", 32'(irq), 32'h1);
        wr(8'h81);
        chk("R6", "irq masked", 32'(irq), 32'h0);
        chk("R5", "write 1 keeps flag", 32'(rd_data), 32'h80);

        cur_req = "R5";
        wr(8'h41);
        chk("R5", "write 0 clears flag", 32'(rd_data), 32'h40);
        run(31);
        wr(8'h40);
        chk("R5", "set wins over clear write", 32'(rd_data[7]), 32'h1);

        cur_req = "R11";
        wr(8'h41);
        run(31);
        wr(8'hC1);
        chk("R11", "reload beats tap", 32'(rd_data), 32'h40);
        run(31);
        chk("R11", "no flag before new interval", 32'(rd_data[7]), 32'h0);
        run(1);
        chk("R11", "flag from latest reload", 32'(rd_data[7]), 32'h1);

        cur_req = "R4";
        wr(8'h43);
        run(2 * 64 - 1);
        chk("R4", "sel1 early", 32'(rd_data[7]), 32'h0);
        run(1);
        chk("R4", "sel1 interval", 32'(rd_data[7]), 32'h1);
        wr(8'h61);
        run(2 * 256 - 1);
        chk("R4", "sel2 early", 32'(rd_data[7]), 32'h0);
        run(1);
        chk("R4", "sel2 interval", 32'(rd_data[7]), 32'h1);
        wr(8'h63);
        run(2 * 8192 - 1);
        chk("R4", "sel3 early", 32'(rd_data[7]), 32'h0);
        run(1);
        chk("R4", "sel3 interval", 32'(rd_data[7]), 32'h1);

        cur_req = "R12";
        wr(8'h5C);
        chk("R12", "unused bits read 0", 32'(rd_data), 32'h40);

        cur_req = "R7";
        wsel = 1'b1;
        main_run = 1'b0;
        run(1);
        chk("R7", "halt reload", 32'(tbase), 32'hFFFF);
        chk("R10", "wdt clear on halt", 32'(wdt_clr), 32'h1);
        run(60);
        chk("R7", "held while halted", 32'(tbase), 32'hFFFF);
        chk("R7", "no flag while halted", 32'(rd_data[7]), 32'h0);
        main_run = 1'b1;
        run(2);
        chk("R10", "wdt clear ends", 32'(wdt_clr), 32'h0);

        cur_req = "R8";
        run(20);
        mode = 3'd4;
        run(1);
        chk("R8", "main to stop reloads", 32'(tbase), 32'hFFFF);
        run(10);
        mode = 3'd0;
        run(1);
        chk("R8", "stop to main no reload", 32'(wdt_clr), 32'h0);
        run(10);
        mode = 3'd1;
        run(10);
        mode = 3'd2;
        run(1);
        chk("R8", "main-PLL to sub reloads", 32'(wdt_clr), 32'h1);
        run(10);
        mode = 3'd3;
        run(1);
        chk("R8", "sub to sub-PLL no reload", 32'(wdt_clr), 32'h0);
        run(5);
        mode = 3'd0;
        run(20);

        cur_req = "R9";
        lvd = 1'b1;
        run(1);
        lvd = 1'b0;
        chk("R9", "lvd reload", 32'(tbase), 32'hFFFF);
        chk("R10", "wdt clear on lvd", 32'(wdt_clr), 32'h1);
        run(10);

        cur_req = "R10";
        wsel = 1'b0;
        wr(8'h41);
        chk("R10", "no wdt clear when unselected", 32'(wdt_clr), 32'h0);
        run(10);

        finish_up();
    end

endmodule